// File: doc/BRIEF.md
# Convert and Bit-Clock Frame Generator

This block runs off a 256-times-sample-rate reference clock and produces the timing pair that a dual successive-approximation converter needs at four-times oversampling: a one-cycle `convert` pulse that starts every conversion, and a gapped burst of 19 `bit_clk` pulses that steps the converter through its bit decisions. A frame is 64 reference cycles long. Each frame also raises a `frame_start` strobe so that logic downstream can align to the frame. One reference cycle is called a slot here, and slots are numbered 0 to 63 within a frame.

The sequence is driven by a five-state machine. In `ST_IDLE` the outputs are low and the slot counter is at zero. `ST_CONV` covers slot 0, the only slot in which `convert` is high. `ST_SETTLE` covers slots 1 to 3, where the bit clock is held low so that no edge falls near the first bit decision. `ST_BURST` covers slots 4 to 58 and issues one high slot followed by two low slots per pulse. `ST_ACQ` covers slots 59 to 63, the quiet window in which the converter acquires its input.

The transitions are as follows. From `ST_IDLE` the machine goes to `ST_CONV` when enable is high. From `ST_CONV` it goes to `ST_SETTLE` after the last convert slot. From `ST_SETTLE` it goes to `ST_BURST` at the end of slot 3. From `ST_BURST` it goes to `ST_ACQ` after the high slot of the 19th pulse. From `ST_ACQ` it goes back to `ST_CONV` when the slot counter wraps. From any state the machine goes to `ST_IDLE` when enable is sampled low. All outputs are registered from the next-state decode, so they are free of glitches.

Top module: `cvg_frame_gen`

## Requirements
- R1: While reset is asserted, `convert`, `bit_clk` and `frame_start` are all low.
- R2: With enable held high, `convert` rises exactly once every 64 cycles.
- R3: `convert` is high for exactly one cycle. It is high in the first cycle after the first clock edge at which enable is sampled high following a period with enable low.
- R4: `frame_start` is high only in the cycle in which `convert` is high, and in every such cycle.
- R5: `bit_clk` is low in the three cycles that follow the `convert` cycle, so the first `bit_clk` high cycle comes 4 cycles after `convert` rises.
- R6: During the burst, `bit_clk` is high for 1 cycle and then low for 2 cycles, so consecutive rising edges are 3 cycles apart.
- R7: Each full frame contains exactly 19 `bit_clk` high cycles. The last one falls in slot 58.
- R8: `bit_clk` stays low in slots 59 to 63, which gives 6 cycles from the 19th rising edge to the next `convert` rise.
- R9: When enable is sampled low at a clock edge, all three outputs are low in the following cycle and the frame position returns to slot 0. A later enable starts a new frame at slot 0.
- R10: `bit_clk` and `convert` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock at 64 cycles per conversion frame |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; when low, holds the generator idle at slot 0 |
| convert | output | 1 | Start-of-conversion pulse, one cycle per frame |
| bit_clk | output | 1 | Gapped 19-pulse bit clock |
| frame_start | output | 1 | Frame alignment strobe, high in slot 0 |

## Verification
Two events can land in the same cycle: enable being withdrawn, and the machine reaching a frame boundary or a bit-clock high slot. The bench provokes the first case directly by dropping enable on the very cycle in which `convert` is showing. It provokes the second by dropping enable on a `bit_clk` high cycle. Random enable gaps then add further collisions at arbitrary slots. A bench-side slot model judges every cycle: the gap must win, the outputs must go quiet on the next cycle, and the next enable must restart the frame at slot 0 with no partial burst carried over.

// File: rtl/cvg_pkg.sv
package cvg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CONV   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_BURST  = 3'd3,
        ST_ACQ    = 3'd4
    } cvg_state_e;

endpackage

// File: rtl/cvg_slot_ctr.sv
module cvg_slot_ctr #(
    parameter int SLOTS = 64,
    localparam int CW = $clog2(SLOTS)
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hold,
    output logic [CW-1:0] slot_q
);

    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    logic [CW-1:0] slot_d;

    always_comb begin
        if (clear || hold) begin
            slot_d = clear ? '0 : slot_q;
        end else if (slot_q == LAST) begin
            slot_d = '0;
        end else begin
            slot_d = slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    // R2: the frame index wraps from the last slot straight to zero
    a_r2_slot_wrap: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (slot_q == LAST && !clear && !hold) |=> (slot_q == '0));

    // R9: a clear always lands the index on slot zero
    a_r9_clear_zero: assert property (@(posedge clk_ref) disable iff (!rst_n)
        clear |=> (slot_q == '0));

endmodule

// File: rtl/cvg_burst_seq.sv
module cvg_burst_seq #(
    parameter int PER    = 3,
    parameter int HIGH   = 1,
    parameter int PULSES = 19,
    localparam int PHW = (PER > 1) ? $clog2(PER) : 1,
    localparam int PCW = (PULSES > 1) ? $clog2(PULSES) : 1
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic advance,
    input  logic enter,
    output logic hi_d,
    output logic last
);

    logic [PHW-1:0] phase_q, phase_d;
    logic [PCW-1:0] pulse_q, pulse_d;

    always_comb begin
        phase_d = phase_q;
        pulse_d = pulse_q;
        if (!advance || enter) begin
            phase_d = '0;
            pulse_d = '0;
        end else if (phase_q == PHW'(PER - 1)) begin
            phase_d = '0;
            pulse_d = pulse_q + 1'b1;
        end else begin
            phase_d = phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            pulse_q <= '0;
        end else begin
            phase_q <= phase_d;
            pulse_q <= pulse_d;
        end
    end

    assign hi_d = advance && (phase_d < PHW'(HIGH));
    assign last = (pulse_q == PCW'(PULSES - 1)) && (phase_q == PHW'(HIGH - 1));

    // R7: the pulse index never runs past the burst length
    a_r7_pulse_bound: assert property (@(posedge clk_ref) disable iff (!rst_n)
        pulse_q < PCW'(PULSES));

    // R6: the phase index stays within one bit-clock period
    a_r6_phase_bound: assert property (@(posedge clk_ref) disable iff (!rst_n)
        phase_q < PHW'(PER));

endmodule

// File: rtl/cvg_frame_gen.sv
module cvg_frame_gen
    import cvg_pkg::*;
#(
    parameter int SLOTS  = 64,
    parameter int CONV_W = 1,
    parameter int LEAD   = 4,
    parameter int PER    = 3,
    parameter int HIGH   = 1,
    parameter int PULSES = 19
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic en,
    output logic convert,
    output logic bit_clk,
    output logic frame_start
);

    localparam int CW = $clog2(SLOTS);

    cvg_state_e    state_q, state_d;
    logic [CW-1:0] slot_q;
    logic          burst_hi_d;
    logic          burst_last;
    logic          enter_burst;
    logic          in_burst_d;
    logic          idle_now;

    assign idle_now    = (state_q == ST_IDLE);
    assign in_burst_d  = (state_d == ST_BURST);
    assign enter_burst = in_burst_d && (state_q != ST_BURST);

    cvg_slot_ctr #(.SLOTS(SLOTS)) u_slot (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .clear   (!en),
        .hold    (idle_now),
        .slot_q  (slot_q)
    );

    cvg_burst_seq #(.PER(PER), .HIGH(HIGH), .PULSES(PULSES)) u_burst (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .advance (in_burst_d),
        .enter   (enter_burst),
        .hi_d    (burst_hi_d),
        .last    (burst_last)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_CONV;
                ST_CONV:   if (slot_q == CW'(CONV_W - 1)) state_d = ST_SETTLE;
                ST_SETTLE: if (slot_q == CW'(LEAD - 1))   state_d = ST_BURST;
                ST_BURST:  if (burst_last)                state_d = ST_ACQ;
                ST_ACQ:    if (slot_q == CW'(SLOTS - 1))  state_d = ST_CONV;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            convert     <= 1'b0;
            bit_clk     <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            convert     <= (state_d == ST_CONV);
            bit_clk     <= burst_hi_d;
            frame_start <= (state_d == ST_CONV) && (state_q != ST_CONV);
        end
    end

    // R10: convert and bit clock never overlap
    a_r10_no_overlap: assert property (@(posedge clk_ref) disable iff (!rst_n)
        convert |-> !bit_clk);

    // R4: the frame strobe only accompanies convert
    a_r4_strobe_with_conv: assert property (@(posedge clk_ref) disable iff (!rst_n)
        frame_start |-> convert);

    // R4: the frame strobe coincides with the counter at slot zero
    a_r4_strobe_slot0: assert property (@(posedge clk_ref) disable iff (!rst_n)
        frame_start |-> (slot_q == '0));

    // R9: a low enable silences every output on the next cycle
    a_r9_disable_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !en |=> (!convert && !bit_clk && !frame_start));

    generate
        if (CONV_W == 1) begin : g_conv_one
            // R3: convert lasts a single cycle
            a_r3_conv_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
                convert |=> !convert);
        end
        if (HIGH == 1) begin : g_high_one
            // R6: each bit-clock high phase lasts a single cycle
            a_r6_high_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
                bit_clk |=> !bit_clk);
        end
    endgenerate

endmodule

// File: tb/cvg_frame_gen_bench.sv
`timescale 1ns/1ps
module cvg_frame_gen_bench;

    logic clk_ref = 1'b0;
    logic rst_n   = 1'b0;
    logic en      = 1'b0;
    logic convert, bit_clk, frame_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cycles = 0;

    always #2.5 clk_ref = ~clk_ref;

    cvg_frame_gen u_cvg_frame_gen (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .en          (en),
        .convert     (convert),
        .bit_clk     (bit_clk),
        .frame_start (frame_start)
    );

    function automatic bit f_conv(int s);
        return s == 0;
    endfunction

    function automatic bit f_bclk(int s);
        return (s >= 4) && (s <= 58) && (((s - 4) % 3) == 0);
    endfunction

    function automatic string bclk_tag(int s);
        if (s >= 1 && s <= 3) return "R5";
        if (s >= 4 && s <= 58) return "R6";
        return "R8";
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // bench model of the frame position
    int  m_slot = 0;
    int  e_slot = 0;
    bit  e_off  = 1'b1;
    always @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            m_slot = 0;
            e_off  = 1'b1;
        end else if (!en) begin
            m_slot = 0;
            e_off  = 1'b1;
        end else begin
            e_slot = m_slot;
            e_off  = 1'b0;
            m_slot = (m_slot + 1) % 64;
        end
    end

    // per-cycle comparison, away from the active edge
    int since_conv = 0;
    int rises      = 0;
    bit full       = 1'b0;
    bit prev_conv  = 1'b0;
    bit prev_bclk  = 1'b0;
    always @(negedge clk_ref) begin
        if (rst_n && !done) begin
            cycles++;
            if (e_off) begin
                chk(!convert && !bit_clk && !frame_start, "R9",
                    {convert, bit_clk, frame_start}, 0);
                full = 1'b0;
            end else begin
                chk(convert == f_conv(e_slot), "R3", convert, f_conv(e_slot));
                chk(frame_start == f_conv(e_slot), "R4", frame_start, f_conv(e_slot));
                chk(bit_clk == f_bclk(e_slot), bclk_tag(e_slot), bit_clk, f_bclk(e_slot));
            end
            chk(!(convert && bit_clk), "R10", convert && bit_clk, 0);
            since_conv++;
            if (bit_clk && !prev_bclk) rises++;
            if (convert && !prev_conv) begin
                if (full) begin
                    chk(since_conv == 64, "R2", since_conv, 64);
                    chk(rises == 19, "R7", rises, 19);
                end
                since_conv = 0;
                rises      = 0;
                full       = 1'b1;
            end
            prev_conv = convert;
            prev_bclk = bit_clk;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk_ref);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1750));
        repeat (3) @(negedge clk_ref);
        // R1: outputs quiet while reset is held, even with enable high
        en = 1'b1;
        @(negedge clk_ref);
        chk(!convert && !bit_clk && !frame_start, "R1",
            {convert, bit_clk, frame_start}, 0);
        en = 1'b0;
        @(negedge clk_ref);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_ref);

        // directed: several uninterrupted frames
        en = 1'b1;
        repeat (64 * 4 + 5) @(negedge clk_ref);

        // directed: drop enable on the convert cycle
        while (!convert) @(negedge clk_ref);
        en = 1'b0;
        repeat (3) @(negedge clk_ref);
        en = 1'b1;
        repeat (64 * 2) @(negedge clk_ref);

        // directed: drop enable on a bit-clock high cycle for one cycle
        while (!bit_clk) @(negedge clk_ref);
        en = 1'b0;
        @(negedge clk_ref);
        en = 1'b1;
        repeat (64 * 2 + 3) @(negedge clk_ref);

        // constrained random enable pattern
        for (int i = 0; i < 40; i++) begin
            int on_len;
            int off_len;
            on_len  = $urandom_range(1, 200);
            off_len = $urandom_range(1, 10);
            en = 1'b1;
            repeat (on_len) @(negedge clk_ref);
            en = 1'b0;
            repeat (off_len) @(negedge clk_ref);
        end

        // finish with full frames
        en = 1'b1;
        repeat (64 * 3 + 2) @(negedge clk_ref);
        finish_run();
    end

endmodule